// File: doc/BRIEF.md
# Indirect Memory Access Bridge

The bridge gives a host that only issues byte-wide register accesses a way to reach a 32-bit external memory space. The host first loads the target address into four byte-wide address registers. It then touches a single byte-wide data register. A write to that register starts an external memory write with the written byte. A read from it starts an external memory read, and the host access is held off until the external byte comes back. That byte then completes the host read.

External cycles are handed to a separate bus-cycle engine through a request/acknowledge handshake. Each request carries one one-hot chip-select. Four zone configuration registers each hold an enable bit for indirect access. When several enables are set, the lowest-numbered zone is chosen and the other enables are ignored. With no enable set, a data-register access completes at once and no external cycle starts. The address registers are never cleared by a cycle, so repeated data accesses reuse one address.

Host protocol: the host holds `host_req` together with `host_ofs`, `host_we` and `host_wdata`. The access completes on the rising clock edge where `host_req` is high and `host_wait` is low. For a read, `host_rdata` is valid in that same cycle.

Top module: `ind_mem_bridge`

## Requirements
- R1: After reset all address bytes and all zone enables read as 0, and both `host_wait` and `bus_req` are low.
- R2: Offsets 0 to 3 are the address bytes, and offset k holds address bits 8k+7 down to 8k. They are read and written with no wait and drive `bus_addr`.
- R3: A host write to offset 4 while some zone is enabled issues exactly one bus cycle with `bus_we`=1, `bus_addr` equal to the loaded address and `bus_wdata` equal to the written byte.
- R4: A host read of offset 4 while some zone is enabled issues exactly one bus cycle with `bus_we`=0. The host read completes with the `bus_rdata` byte presented alongside `bus_ack`.
- R5: Offsets 8 to 11 are the configuration registers of zones 0 to 3, with the enable in bit 0. Bits 7 to 1 always read 0.
- R6: `bus_cs` is one-hot. It selects the lowest-numbered enabled zone, so zone 0 has the highest priority and zone 3 the lowest.
- R7: With no zone enabled, an access to offset 4 completes with no wait and starts no bus cycle. A read returns 0xFF and a written byte is dropped.
- R8: From the data-register access until the cycle after `bus_ack`, `host_wait` stays high and the bus request fields stay unchanged. A host access lasts exactly L+3 waited cycles when the engine raises `bus_ack` L+1 cycles after `bus_req` rises.
- R9: The address registers keep their values across bus cycles, so back-to-back data accesses target the same address.
- R10: Offsets 5 to 7 and 12 to 15 read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until completion |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_ofs | input | 4 | Register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the completing cycle |
| host_wait | output | 1 | Host access stalled |
| bus_req | output | 1 | External cycle request to bus engine |
| bus_we | output | 1 | External cycle is a write |
| bus_addr | output | 32 | External address |
| bus_wdata | output | 8 | External write byte |
| bus_cs | output | 4 | One-hot chip-select of the target zone |
| bus_ack | input | 1 | One-cycle completion pulse from bus engine |
| bus_rdata | input | 8 | External read byte, valid with bus_ack |

## Verification
The bench targets enable patterns with several bits set. A priority encoder that is reversed or not one-hot would drive the wrong chip-select or several at once. It varies engine latency and counts waited host cycles. A bridge that releases the host early would return stale read data, and one that drops the request early would shorten or lose the bus cycle. It also tests data accesses with no zone enabled and writes to unused offsets. A design that got these wrong would start a phantom external cycle, hang the host, or corrupt the loaded address.

// File: rtl/ind_mem_bridge.sv
module ind_mem_bridge #(
  parameter int ADDR_W = 32,
  parameter int ZONES  = 4,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [OFS_W-1:0]  host_ofs,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_wait,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  output logic [ZONES-1:0]  bus_cs,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata
);
  localparam int NBYTES   = ADDR_W / 8;
  localparam int DATA_OFS = NBYTES;
  localparam int CFG_OFS  = 2 * NBYTES;

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_t;

  state_t             state;
  logic [ADDR_W-1:0]  addr_q;
  logic [ZONES-1:0]   zen_q;
  logic [ZONES-1:0]   cs_q;
  logic [ZONES-1:0]   pick;
  logic               we_q;
  logic [7:0]         wdata_q;
  logic [7:0]         rbuf;

  wire any_en   = |zen_q;
  wire hit_data = host_req && (host_ofs == OFS_W'(DATA_OFS));
  wire start    = (state == S_IDLE) && hit_data && any_en;
  wire reg_wr   = host_req && host_we && (state == S_IDLE) && !hit_data;

  always_comb begin
    pick = '0;
    for (int i = ZONES - 1; i >= 0; i--)
      if (zen_q[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      zen_q   <= '0;
      cs_q    <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rbuf    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_BUSY;
          cs_q    <= pick;
          we_q    <= host_we;
          wdata_q <= host_wdata;
        end
        S_BUSY: if (bus_ack) begin
          state <= S_DONE;
          rbuf  <= bus_rdata;
        end
        default: state <= S_IDLE;
      endcase
      if (reg_wr) begin
        for (int i = 0; i < NBYTES; i++)
          if (host_ofs == OFS_W'(i)) addr_q[8*i +: 8] <= host_wdata;
        for (int i = 0; i < ZONES; i++)
          if (host_ofs == OFS_W'(CFG_OFS + i)) zen_q[i] <= host_wdata[0];
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (state == S_DONE)
      host_rdata = rbuf;
    else if (host_ofs == OFS_W'(DATA_OFS))
      host_rdata = 8'hFF;
    else begin
      for (int i = 0; i < NBYTES; i++)
        if (host_ofs == OFS_W'(i)) host_rdata = addr_q[8*i +: 8];
      for (int i = 0; i < ZONES; i++)
        if (host_ofs == OFS_W'(CFG_OFS + i)) host_rdata = {7'b0, zen_q[i]};
    end
  end

  assign host_wait = (state == S_BUSY) || start;
  assign bus_req   = (state == S_BUSY);
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_cs    = cs_q;

  assert_cs_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> $countones(bus_cs) == 1);

  assert_zone0_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && zen_q[0]) |-> bus_cs[0]);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_wdata) && $stable(bus_cs)));

  assert_host_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> host_wait);

  assert_no_zone_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !any_en |=> !bus_req);

endmodule

// File: tb/ind_mem_bridge_bench.sv
`timescale 1ns/1ps
module ind_mem_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [3:0]  host_ofs = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_wait;
  logic        bus_req, bus_we, bus_ack = 1'b0;
  logic [31:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata = '0;
  logic [3:0]  bus_cs;

  always #2 clk = ~clk;

  ind_mem_bridge u_ind_mem_bridge (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_wait(host_wait), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cs(bus_cs),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  int nchecks = 0, nerr = 0;
  int lat = 0, cnt = 0, cycles = 0, unstable = 0;
  logic [31:0] log_addr, sv_addr;
  logic        log_we, sv_we;
  logic [7:0]  log_wd, sv_wd;
  logic [3:0]  log_cs, sv_cs;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[31:24] ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (bus_ack) begin
      bus_ack <= 1'b0;
      cnt     <= 0;
    end else if (bus_req) begin
      if (cnt == 0) begin
        sv_addr <= bus_addr; sv_we <= bus_we; sv_wd <= bus_wdata; sv_cs <= bus_cs;
      end else if (bus_addr !== sv_addr || bus_we !== sv_we || bus_wdata !== sv_wd || bus_cs !== sv_cs)
        unstable <= unstable + 1;
      if (cnt == lat) begin
        bus_ack   <= 1'b1;
        bus_rdata <= mem_byte(bus_addr);
        log_addr  <= bus_addr; log_we <= bus_we; log_wd <= bus_wdata; log_cs <= bus_cs;
        cycles    <= cycles + 1;
      end
      cnt <= cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchecks++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic access(input logic [3:0] ofs, input logic we, input logic [7:0] d,
                        output logic [7:0] q, output int waits);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_ofs = ofs; host_wdata = d;
    waits = 0;
    #0.5;
    while (host_wait) begin
      waits++;
      @(negedge clk);
      #0.5;
    end
    q = host_rdata;
    @(posedge clk);
    #0.5;
    host_req = 1'b0;
  endtask

  task automatic wr(input logic [3:0] ofs, input logic [7:0] d);
    logic [7:0] q; int w;
    access(ofs, 1'b1, d, q, w);
  endtask

  task automatic rd(input logic [3:0] ofs, output logic [7:0] q);
    int w;
    access(ofs, 1'b0, 8'h00, q, w);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  endtask

  // addr[52:21] en[20:17] we[16] wd[15:8] cs[7:4] lat[3:0]
  localparam logic [52:0] VEC [8] = '{
    {32'h1234_5678, 4'b0001, 1'b1, 8'hA5, 4'b0001, 4'd0},
    {32'hDEAD_BEEF, 4'b0011, 1'b0, 8'h00, 4'b0001, 4'd3},
    {32'h0000_00FF, 4'b0110, 1'b1, 8'h3C, 4'b0010, 4'd1},
    {32'hFFFF_FFFF, 4'b1100, 1'b0, 8'h00, 4'b0100, 4'd5},
    {32'h8000_0001, 4'b1000, 1'b1, 8'h00, 4'b1000, 4'd2},
    {32'hCAFE_0042, 4'b1111, 1'b0, 8'h00, 4'b0001, 4'd0},
    {32'h0F0F_F0F0, 4'b1010, 1'b0, 8'h00, 4'b0010, 4'd7},
    {32'h7654_3210, 4'b1110, 1'b1, 8'hFF, 4'b0010, 4'd4}
  };

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] q;
    int w, c0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #0.5;
    chk("R1 host_wait", host_wait, 0);
    chk("R1 bus_req", bus_req, 0);
    for (int i = 0; i < 4; i++) begin rd(4'(i), q); chk("R1 addr byte", q, 0); end
    for (int i = 8; i < 12; i++) begin rd(4'(i), q); chk("R1 zone en", q, 0); end

    // R2 byte lanes
    wr(4'd0, 8'h11); wr(4'd1, 8'h22); wr(4'd2, 8'h33); wr(4'd3, 8'h44);
    chk("R2 bus_addr lanes", bus_addr, 32'h4433_2211);
    rd(4'd2, q); chk("R2 readback", q, 8'h33);

    // R5 config bit 0 only
    wr(4'd9, 8'hFF); rd(4'd9, q); chk("R5 cfg readback", q, 8'h01);
    wr(4'd9, 8'hFE); rd(4'd9, q); chk("R5 cfg clear", q, 8'h00);

    // R7 no zone enabled
    c0 = cycles;
    access(4'd4, 1'b1, 8'h5A, q, w);
    chk("R7 write waits", w, 0);
    access(4'd4, 1'b0, 8'h00, q, w);
    chk("R7 read waits", w, 0);
    chk("R7 read value", q, 8'hFF);
    repeat (3) @(posedge clk);
    chk("R7 no bus cycle", cycles, c0);

    // R10 unused offsets
    wr(4'd6, 8'hAB); rd(4'd6, q); chk("R10 ofs6 reads 0", q, 0);
    wr(4'd13, 8'hCD); rd(4'd13, q); chk("R10 ofs13 reads 0", q, 0);
    chk("R10 addr untouched", bus_addr, 32'h4433_2211);
    for (int i = 8; i < 12; i++) begin rd(4'(i), q); chk("R10 zones untouched", q, 0); end

    // vector table: R3 R4 R6 R8
    foreach (VEC[k]) begin
      logic [31:0] a;
      logic [3:0]  en;
      a  = VEC[k][52:21];
      en = VEC[k][20:17];
      for (int i = 0; i < 4; i++) wr(4'(i), a[8*i +: 8]);
      for (int i = 0; i < 4; i++) wr(4'(8 + i), {7'b0, en[i]});
      lat = int'(VEC[k][3:0]);
      c0 = cycles;
      access(4'd4, VEC[k][16], VEC[k][15:8], q, w);
      chk("R3 R4 one bus cycle", cycles, c0 + 1);
      chk("R3 R4 bus addr", log_addr, a);
      chk("R3 R4 bus we", log_we, VEC[k][16]);
      chk("R6 chip select", log_cs, VEC[k][7:4]);
      chk("R8 wait length", w, lat + 3);
      if (VEC[k][16]) chk("R3 bus wdata", log_wd, VEC[k][15:8]);
      else            chk("R4 read data", q, mem_byte(a));
    end
    chk("R8 request stable", unstable, 0);

    // R9 address reuse
    lat = 2;
    access(4'd4, 1'b0, 8'h00, q, w);
    chk("R9 first addr", log_addr, 32'h7654_3210);
    access(4'd4, 1'b1, 8'h99, q, w);
    chk("R9 second addr", log_addr, 32'h7654_3210);
    chk("R9 second wdata", log_wd, 8'h99);
    rd(4'd3, q); chk("R9 addr kept", q, 8'h76);

    summary();
  end
endmodule